// File: doc/BRIEF.md
# Memory Sleep Mode Controller

This block governs low-power sleep for a synchronous memory core. An active-high sleep request comes in without a clock relationship. Two flops bring it into the clock domain. Once the synchronized request has been high for two clock edges, the core is held asleep. While asleep, the controller gates every other control input. Commands reaching the core become deselects, and the core's data-output enable is forced off, so the data pins float. Memory contents and core state stay where they are, because nothing in the core changes while it sees only deselects.

When the request falls, the controller opens a recovery window of a fixed number of clock cycles, set by a parameter. Inside the window, the command filter passes deselects and reads. A write is dropped and becomes a deselect, and a sticky error flag records the attempt until reset. When the window closes, all commands pass unchanged. The request is meant to be held low whenever it is not in use.

Top module: `memsleep_ctrl`

## Requirements
- R1: After reset, sleeping, recovering and wr_reject_err are 0, inputs_en is 1, and a command on cmd_in appears unchanged on cmd_out. The command code is 0 = deselect, 1 = read, 2 = write, 3 = reserved.
- R2: sleep_req passes through two synchronizing flops. When sleep_req rises and stays high, sleeping rises after the fourth rising clock edge: two edges to synchronize, then a fixed two-edge entry delay.
- R3: A sleep_req pulse of one clock cycle never sets sleeping, because the entry is abandoned when the synchronized request drops during the entry delay.
- R4: While sleeping is 1, cmd_out is 0 (deselect) for every cmd_in, dq_oe is 0 whatever core_oe is, force_hiz is 1 and inputs_en is 0.
- R5: A write on cmd_in while sleeping is 1 does not set wr_reject_err.
- R6: When sleep_req falls, sleeping drops and recovering rises after the third rising edge. recovering then stays 1 for exactly RECOV_CYC cycles and returns to 0.
- R7: While recovering is 1, a read (1) or a deselect (0) on cmd_in passes to cmd_out, and a write (2) is turned into a deselect (0).
- R8: A write on cmd_in in a cycle with recovering = 1 sets wr_reject_err on the following edge. wr_reject_err then stays 1 until reset.
- R9: Outside sleep, a reserved code (3) on cmd_in leaves as a deselect (0).
- R10: If sleep_req rises again during recovery, recovering drops after the third rising edge and sleeping rises after the fourth.
- R11: Whenever sleeping is 0, dq_oe follows core_oe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Sleep request, active high, not synchronous to clk |
| cmd_in | input | 2 | Command from the controller side (0 deselect, 1 read, 2 write, 3 reserved) |
| core_oe | input | 1 | Data-output enable requested by the core |
| cmd_out | output | 2 | Filtered command delivered to the core |
| dq_oe | output | 1 | Data-output enable to the pin drivers |
| sleeping | output | 1 | Core is asleep |
| inputs_en | output | 1 | Control inputs are accepted (low while asleep) |
| force_hiz | output | 1 | Data pins forced to high impedance |
| recovering | output | 1 | Recovery window after wake-up is open |
| wr_reject_err | output | 1 | Sticky flag: a write was dropped during recovery |

## Verification
Commands and core_oe are drawn at random in each phase: awake, asleep and recovering. Comparing the three phases shows that the filter acts on the sleep state and not on the command alone. A held request is checked against a one-cycle pulse, which separates a correct entry delay from one that sleeps on any glitch. Recovery is tried twice. The first time carries only reads and deselects, and the error flag must stay clear. The second time carries a write, and the flag must set. A run that ends with the request reasserted inside the window confirms the direct path back into sleep.

// File: rtl/memsleep_pkg.sv
package memsleep_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ENTER  = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_RECOV  = 2'd3
    } pwr_st_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/memsleep_sync.sv
module memsleep_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.sh[STAGES-1];

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(async_in, STAGES));

endmodule

// File: rtl/memsleep_fsm.sv
module memsleep_fsm
    import memsleep_pkg::*;
#(
    parameter int unsigned RECOV_CYC = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_s,
    output pwr_st_e st
);
    localparam int unsigned CW = (RECOV_CYC < 2) ? 1 : $clog2(RECOV_CYC + 1);

    typedef struct packed {
        pwr_st_e       st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_AWAKE: begin
                if (req_s) fsm_d.st = ST_ENTER;
            end
            ST_ENTER: begin
                fsm_d.st = req_s ? ST_ASLEEP : ST_AWAKE;
            end
            ST_ASLEEP: begin
                if (!req_s) begin
                    fsm_d.st  = ST_RECOV;
                    fsm_d.cnt = CW'(RECOV_CYC);
                end
            end
            ST_RECOV: begin
                if (req_s) begin
                    fsm_d.st  = ST_ENTER;
                    fsm_d.cnt = '0;
                end else if (fsm_q.cnt <= CW'(1)) begin
                    fsm_d.st  = ST_AWAKE;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - CW'(1);
                end
            end
            default: fsm_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_AWAKE, cnt: '0};
        else        fsm_q <= fsm_d;
    end

    assign st = fsm_q.st;

    // R2
    entry_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.st == ST_ASLEEP) |-> ($past(req_s) && $past(req_s, 2)));

    // R6
    wake_to_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fsm_q.st == ST_ASLEEP) |-> (fsm_q.st == ST_RECOV));

    // R6
    recov_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_RECOV) |-> (fsm_q.cnt != '0 && fsm_q.cnt <= CW'(RECOV_CYC)));

endmodule

// File: rtl/memsleep_cmd_filter.sv
module memsleep_cmd_filter
    import memsleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_st_e    st,
    input  logic [1:0] cmd_in,
    output logic [1:0] cmd_out,
    output logic       err
);
    typedef struct packed {
        logic err;
    } flt_t;

    flt_t flt_d, flt_q;
    cmd_e cmd_c;
    cmd_e pass_c;

    assign cmd_c = cmd_e'(cmd_in);

    always_comb begin
        pass_c = cmd_c;
        if (cmd_c == CMD_RSVD) pass_c = CMD_DESEL;
        unique case (st)
            ST_ASLEEP: pass_c = CMD_DESEL;
            ST_RECOV:  if (cmd_c == CMD_WRITE) pass_c = CMD_DESEL;
            default:   ;
        endcase
    end

    always_comb begin
        flt_d = flt_q;
        if (st == ST_RECOV && cmd_c == CMD_WRITE) flt_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign cmd_out = pass_c;
    assign err     = flt_q.err;

    // R7
    recov_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECOV) |-> (cmd_out != CMD_WRITE));

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECOV && cmd_in == CMD_WRITE) |=> err);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R4
    asleep_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ASLEEP) |-> (cmd_out == CMD_DESEL));

endmodule

// File: rtl/memsleep_ctrl.sv
module memsleep_ctrl
    import memsleep_pkg::*;
#(
    parameter int unsigned RECOV_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic [1:0] cmd_in,
    input  logic       core_oe,
    output logic [1:0] cmd_out,
    output logic       dq_oe,
    output logic       sleeping,
    output logic       inputs_en,
    output logic       force_hiz,
    output logic       recovering,
    output logic       wr_reject_err
);
    logic    req_s;
    pwr_st_e st;

    memsleep_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    memsleep_fsm #(.RECOV_CYC(RECOV_CYC)) fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req_s (req_s),
        .st    (st)
    );

    memsleep_cmd_filter filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .cmd_in  (cmd_in),
        .cmd_out (cmd_out),
        .err     (wr_reject_err)
    );

    assign sleeping   = (st == ST_ASLEEP);
    assign recovering = (st == ST_RECOV);
    assign inputs_en  = !sleeping;
    assign force_hiz  = sleeping;
    assign dq_oe      = core_oe && !force_hiz;

    // R4
    hiz_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> (!dq_oe && !inputs_en));

    // R11
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping |-> (dq_oe == core_oe));

endmodule

// File: tb/memsleep_ctrl_tb_top.sv
module memsleep_ctrl_tb_top;
    localparam int unsigned RC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [1:0] cmd_in = 2'd0;
    logic       core_oe = 1'b0;
    logic [1:0] cmd_out;
    logic       dq_oe, sleeping, inputs_en, force_hiz, recovering, wr_reject_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    memsleep_ctrl #(.RECOV_CYC(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cmd_in(cmd_in),
        .core_oe(core_oe), .cmd_out(cmd_out), .dq_oe(dq_oe), .sleeping(sleeping),
        .inputs_en(inputs_en), .force_hiz(force_hiz), .recovering(recovering),
        .wr_reject_err(wr_reject_err)
    );

    // phase: 0 awake, 1 asleep, 2 recovering
    function automatic logic [1:0] exp_cmd(int phase, logic [1:0] c);
        if (phase == 1) return 2'd0;
        if (c == 2'd3) return 2'd0;
        if (phase == 2 && c == 2'd2) return 2'd0;
        return c;
    endfunction

    function automatic logic exp_oe(int phase, logic oe);
        return (phase == 1) ? 1'b0 : oe;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive a random command at negedge and check the combinational result
    task automatic rand_cmds(int phase, int n, bit allow_wr, string req);
        for (int i = 0; i < n; i++) begin
            logic [1:0] c;
            logic oe;
            @(negedge clk);
            c = 2'($urandom_range(0, 3));
            if (!allow_wr && c == 2'd2) c = 2'd1;
            oe = 1'($urandom_range(0, 1));
            cmd_in  = c;
            core_oe = oe;
            #1;
            chk(req, 32'(cmd_out), 32'(exp_cmd(phase, c)));
            chk((phase == 1) ? "R4 oe" : "R11 oe", 32'(dq_oe), 32'(exp_oe(phase, oe)));
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        cmd_in = 2'd0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 sleeping", 32'(sleeping), 0);
        chk("R1 recovering", 32'(recovering), 0);
        chk("R1 err", 32'(wr_reject_err), 0);
        chk("R1 inputs_en", 32'(inputs_en), 1);
        cmd_in = 2'd1; #1;
        chk("R1 pass", 32'(cmd_out), 1);

        // R9 / R11 awake random
        rand_cmds(0, 30, 1'b1, "R9 awake");
        quiet();

        // R3 one-cycle pulse never sleeps
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R3 pulse", 32'(sleeping), 0);
        end

        // R2 held request: sleeping after 4th edge
        sleep_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 early", 32'(sleeping), 0);
        end
        @(negedge clk);
        chk("R2 entered", 32'(sleeping), 1);
        chk("R4 hiz", 32'(force_hiz), 1);
        chk("R4 inputs_en", 32'(inputs_en), 0);

        // R4 / R5 asleep random incl. writes
        rand_cmds(1, 25, 1'b1, "R4 asleep");
        @(negedge clk); cmd_in = 2'd2;
        @(negedge clk); cmd_in = 2'd0;
        chk("R5 no err", 32'(wr_reject_err), 0);

        // R6 exit: recovering after 3rd edge, lasts RC cycles; R7 reads only
        sleep_req = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R6 still asleep", 32'(sleeping), 1);
        end
        for (int i = 0; i < RC; i++) begin
            logic [1:0] c;
            @(negedge clk);
            chk("R6 recovering", 32'(recovering), 1);
            chk("R6 awake", 32'(sleeping), 0);
            c = (i % 2 == 0) ? 2'd1 : 2'd0;
            cmd_in = c; #1;
            chk("R7 pass", 32'(cmd_out), 32'(c));
        end
        @(negedge clk);
        cmd_in = 2'd0;
        chk("R6 window end", 32'(recovering), 0);
        chk("R8 clear", 32'(wr_reject_err), 0);
        rand_cmds(0, 10, 1'b1, "R9 after recov");
        quiet();

        // second sleep; write during recovery
        sleep_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 second", 32'(sleeping), 1);
        sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 second", 32'(recovering), 1);
        cmd_in = 2'd2; #1;
        chk("R7 write blocked", 32'(cmd_out), 0);
        @(negedge clk);
        cmd_in = 2'd1; #1;
        chk("R8 err set", 32'(wr_reject_err), 1);
        chk("R7 read", 32'(cmd_out), 1);
        repeat (RC + 2) @(negedge clk);
        chk("R8 sticky", 32'(wr_reject_err), 1);
        cmd_in = 2'd2; #1;
        chk("R9 write awake", 32'(cmd_out), 2);
        quiet();

        // R10 re-request during recovery
        sleep_req = 1'b1;
        repeat (4) @(negedge clk);
        sleep_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 in recov", 32'(recovering), 1);
        sleep_req = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R10 recov held", 32'(recovering), 1);
        end
        @(negedge clk);
        chk("R10 recov left", 32'(recovering), 0);
        chk("R10 not yet", 32'(sleeping), 0);
        @(negedge clk);
        chk("R10 asleep", 32'(sleeping), 1);

        // R8 reset clears
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R8 reset clears", 32'(wr_reject_err), 0);
        chk("R1 reset sleeping", 32'(sleeping), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule